// File: doc/BRIEF.md
# Audio sample format converter

This block is a streaming reshaper placed between a client audio port and a port of an audio switch fabric. Each sample travels as one 32-bit lane word with a channel index beside it. The block changes the sample resolution, making it wider or narrower. It also changes the channel count in two ways: it can fold a stereo pair into one mono sample, or it can split a mono sample into a stereo pair. Samples are signed two's complement, left-justified in the lane, so the most significant bit of every width sits at lane bit 31.

A set of static configuration inputs gives the format of each side: a width code and a channel count for the audio side, and the same two settings for the client side. A direction bit picks which side is the source. Further mode inputs choose how new low bits are filled when widening, whether narrowing rounds or truncates, how a pair is folded, and what fills the added channel when a mono sample is split. Both the input and the output use a valid/ready handshake. The output is registered. The configuration must only change while no sample is in flight.

Top module: `afmt_conv`

## Requirements
- R1: A width code c (0..7) means 4*(c+1) bits. The source sample keeps only its top 4*(c+1) lane bits; all lower bits are treated as zero. When source and destination widths are equal, this masked value is passed unchanged.
- R2: When the destination is wider, the lane bits between the source width and the destination width are filled according to the fill mode: mode 0 fills zeros, mode 1 fills ones, and mode 3 fills zeros. Lane bits below the destination width are zero.
- R3: Fill mode 2 fills those bits from the matching bit positions of the word {L,L}, where L is a 16-bit shift register. L starts at 0xACE1 after reset. After each sample that is emitted with widening, L advances once to {L[14:0], L[15]^L[13]^L[12]^L[10]}.
- R4: When the destination is narrower and the chop input is 1, the output keeps the top destination-width bits of the masked source and zeroes the bits below them.
- R5: When the destination is narrower and chop is 0, the output rounds half up. It adds half of one destination LSB and then truncates. A non-negative sample that would overflow saturates to the largest positive destination value.
- R6: With the direction input at 0, the client side is the source and the audio side is the destination. With the direction input at 1, the audio side is the source and the client side is the destination.
- R7: With two source channels and one destination channel, a channel-0 sample is held and produces no output. The following channel-1 sample produces one output on channel 0. That output is the held channel 0 for fold mode 0, channel 1 for fold mode 1, and the average for fold modes 2 and 3.
- R8: The average is the sum of the two signed samples, computed with one extra bit, shifted right arithmetically by one.
- R9: With one source channel and two destination channels, each channel-0 input produces a channel-0 output and then, on the next output transfer, a channel-1 output. The channel-1 output is zero when the duplicate input is 0 and a copy of the converted channel-0 output when it is 1. No input is accepted until the channel-1 output is loaded.
- R10: An input whose channel index exceeds the source count minus one is consumed with no output. In the other channel cases, an input whose index exceeds the destination count minus one is also dropped. Every other input keeps its channel index. Channel counts are programmed as the count minus one.
- R11: While out_valid is 1 and out_ready is 0, out_data and out_chan hold their values, out_valid stays 1, and in_ready is 0.
- R12: After reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_dir | input | 1 | 0: client side is the source; 1: audio side is the source |
| cfg_aud_width | input | 3 | Audio-side width code |
| cfg_cli_width | input | 3 | Client-side width code |
| cfg_aud_chans | input | CHAN_W | Audio-side channel count minus one |
| cfg_cli_chans | input | CHAN_W | Client-side channel count minus one |
| cfg_fill | input | 2 | Widening fill mode |
| cfg_chop | input | 1 | Narrowing: 1 truncates, 0 rounds |
| cfg_fold | input | 2 | Stereo-to-mono fold mode |
| cfg_dup | input | 1 | Mono-to-stereo: 1 copies the sample into the added channel, 0 puts zero there |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample accepted when high together with in_valid |
| in_data | input | 32 | Input sample, left-justified |
| in_chan | input | CHAN_W | Input channel index |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream accepts the output sample |
| out_data | output | 32 | Output sample, left-justified |
| out_chan | output | CHAN_W | Output channel index |

## Verification
A shift register that steps at the wrong time shows up as a wrong fill pattern on the very next widened sample. The bench checks two consecutive samples after a fresh reset. A stale held channel-0 value shows up in the first folded output after it. A pending second channel that is lost or repeated shows up as a missing or extra output, or as a stuck in_ready, on the transfer that immediately follows. Rounding, saturation and masking faults are visible in the same cycle the sample is loaded. Table vectors therefore sit right at the half-LSB boundary and at the positive limit.

// File: rtl/afmt_pkg.sv
package afmt_pkg;

    localparam int LANE_W = 32;

    typedef enum logic [1:0] {
        FILL_ZERO = 2'd0,
        FILL_ONE  = 2'd1,
        FILL_RAND = 2'd2,
        FILL_RSVD = 2'd3
    } fill_e;

    typedef enum logic [1:0] {
        FOLD_FIRST  = 2'd0,
        FOLD_SECOND = 2'd1,
        FOLD_MEAN   = 2'd2,
        FOLD_MEAN_X = 2'd3
    } fold_e;

    // Lane mask keeping the top 4*(code+1) bits.
    function automatic logic [LANE_W-1:0] keep_mask(input logic [2:0] code);
        logic [4:0] sh;
        sh = 5'd28 - {code, 2'b00};
        return {LANE_W{1'b1}} << sh;
    endfunction

endpackage

// File: rtl/afmt_lfsr.sv
module afmt_lfsr #(
    parameter int          W    = 16,
    parameter logic [W-1:0] TAPS = 16'hB400,
    parameter logic [W-1:0] SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] value
);
    logic [W-1:0] st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step) st_d = {st_q[W-2:0], ^(st_q & TAPS)};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SEED;
        else        st_q <= st_d;
    end

    assign value = st_q;

    AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q != '0); // R3

endmodule

// File: rtl/afmt_width.sv
module afmt_width
    import afmt_pkg::*;
#(
    parameter int RND_W = 16
) (
    input  logic [LANE_W-1:0] x,
    input  logic [2:0]        src_code,
    input  logic [2:0]        dst_code,
    input  logic [1:0]        fill,
    input  logic              chop,
    input  logic [RND_W-1:0]  rnd,
    output logic [LANE_W-1:0] y,
    output logic              widened
);
    localparam int REP = LANE_W / RND_W;

    logic [LANE_W-1:0] k_in, k_out, xm, pat, half;
    logic [LANE_W:0]   sum;
    logic              ovf;

    always_comb begin
        k_in    = keep_mask(src_code);
        k_out   = keep_mask(dst_code);
        xm      = x & k_in;
        widened = dst_code > src_code;
        case (fill_e'(fill))
            FILL_ONE:  pat = {LANE_W{1'b1}};
            FILL_RAND: pat = {REP{rnd}};
            default:   pat = '0;
        endcase
        half = ((~k_out) >> 1) + {{(LANE_W-1){1'b0}}, 1'b1};
        sum  = {xm[LANE_W-1], xm} + {1'b0, half};
        ovf  = !xm[LANE_W-1] && sum[LANE_W-1];
        if (widened)
            y = xm | (pat & k_out & ~k_in);
        else if (dst_code == src_code)
            y = xm;
        else if (chop)
            y = xm & k_out;
        else if (ovf)
            y = {1'b0, {(LANE_W-1){1'b1}}} & k_out;
        else
            y = sum[LANE_W-1:0] & k_out;
    end

endmodule

// File: rtl/afmt_conv.sv
module afmt_conv
    import afmt_pkg::*;
#(
    parameter int          CHAN_W    = 3,
    parameter int          LFSR_W    = 16,
    parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_dir,
    input  logic [2:0]        cfg_aud_width,
    input  logic [2:0]        cfg_cli_width,
    input  logic [CHAN_W-1:0] cfg_aud_chans,
    input  logic [CHAN_W-1:0] cfg_cli_chans,
    input  logic [1:0]        cfg_fill,
    input  logic              cfg_chop,
    input  logic [1:0]        cfg_fold,
    input  logic              cfg_dup,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [31:0]       in_data,
    input  logic [CHAN_W-1:0] in_chan,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [31:0]       out_data,
    output logic [CHAN_W-1:0] out_chan
);
    typedef struct packed {
        logic              out_vld;
        logic [31:0]       out_dat;
        logic [CHAN_W-1:0] out_ch;
        logic [31:0]       hold_dat;
        logic              pend;
        logic [31:0]       pend_dat;
    } state_t;

    state_t q, d;

    logic [2:0]        src_w, dst_w;
    logic [CHAN_W-1:0] src_ch, dst_ch;
    logic              fold_mode, dup_mode, load_ok, take, emit_conv;
    logic [32:0]       pair_sum;
    logic [31:0]       folded, conv_src, conv_y;
    logic              widened;
    logic [LFSR_W-1:0] rnd;

    assign src_w     = cfg_dir ? cfg_aud_width : cfg_cli_width;
    assign dst_w     = cfg_dir ? cfg_cli_width : cfg_aud_width;
    assign src_ch    = cfg_dir ? cfg_aud_chans : cfg_cli_chans;
    assign dst_ch    = cfg_dir ? cfg_cli_chans : cfg_aud_chans;
    assign fold_mode = (src_ch == CHAN_W'(1)) && (dst_ch == '0);
    assign dup_mode  = (src_ch == '0) && (dst_ch == CHAN_W'(1));
    assign load_ok   = !q.out_vld || out_ready;
    assign in_ready  = load_ok && !q.pend;
    assign take      = in_valid && in_ready;

    always_comb begin
        pair_sum = {q.hold_dat[31], q.hold_dat} + {in_data[31], in_data};
        case (fold_e'(cfg_fold))
            FOLD_FIRST:  folded = q.hold_dat;
            FOLD_SECOND: folded = in_data;
            default:     folded = pair_sum[32:1];
        endcase
        conv_src = fold_mode ? folded : in_data;
    end

    afmt_width #(.RND_W(LFSR_W)) u_width (
        .x        (conv_src),
        .src_code (src_w),
        .dst_code (dst_w),
        .fill     (cfg_fill),
        .chop     (cfg_chop),
        .rnd      (rnd),
        .y        (conv_y),
        .widened  (widened)
    );

    afmt_lfsr #(.W(LFSR_W), .SEED(LFSR_SEED[LFSR_W-1:0])) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (emit_conv && widened),
        .value (rnd)
    );

    always_comb begin
        d         = q;
        emit_conv = 1'b0;
        if (load_ok) d.out_vld = 1'b0;
        if (q.pend && load_ok) begin
            d.out_vld = 1'b1;
            d.out_dat = q.pend_dat;
            d.out_ch  = CHAN_W'(1);
            d.pend    = 1'b0;
        end else if (take && (in_chan <= src_ch)) begin
            if (fold_mode) begin
                if (in_chan == '0) begin
                    d.hold_dat = in_data;
                end else begin
                    emit_conv = 1'b1;
                    d.out_ch  = '0;
                end
            end else if (dup_mode) begin
                emit_conv  = 1'b1;
                d.out_ch   = '0;
                d.pend     = 1'b1;
                d.pend_dat = cfg_dup ? conv_y : '0;
            end else if (in_chan <= dst_ch) begin
                emit_conv = 1'b1;
                d.out_ch  = in_chan;
            end
            if (emit_conv) begin
                d.out_vld = 1'b1;
                d.out_dat = conv_y;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_valid = q.out_vld;
    assign out_data  = q.out_dat;
    assign out_chan  = q.out_ch;

    AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_chan)); // R11

    AST_STALL_IN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready); // R11

    AST_CHAN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_chan <= dst_ch); // R10

    AST_SAT_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        take && (dst_w < src_w) && !cfg_chop && !conv_src[31] |-> !conv_y[31]); // R5

    AST_DUP_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && dup_mode && out_chan == '0 |=> out_valid && out_chan == CHAN_W'(1)); // R9

endmodule

// File: tb/sim_afmt_conv.sv
module sim_afmt_conv;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_dir = 1'b0;
    logic [2:0]  cfg_aud_width = 3'd7, cfg_cli_width = 3'd7;
    logic [2:0]  cfg_aud_chans = 3'd0, cfg_cli_chans = 3'd0;
    logic [1:0]  cfg_fill = 2'd0, cfg_fold = 2'd0;
    logic        cfg_chop = 1'b0, cfg_dup = 1'b0;
    logic        in_valid = 1'b0, out_ready = 1'b1;
    logic [31:0] in_data = '0;
    logic [2:0]  in_chan = '0;
    logic        in_ready, out_valid;
    logic [31:0] out_data;
    logic [2:0]  out_chan;

    int nchk = 0, nerr = 0;
    logic [34:0] mon_q [$];

    always #4 clk = ~clk;

    afmt_conv u0 (.*);

    always @(negedge clk)
        if (rst_n && out_valid && out_ready) mon_q.push_back({out_chan, out_data});

    typedef struct packed {
        logic [7:0]  req;
        logic        dir;
        logic [2:0]  aw;
        logic [2:0]  cw;
        logic [1:0]  fill;
        logic        chop;
        logic [31:0] din;
        logic [31:0] expv;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TBL [NV] = '{
        '{8'd2, 1'b0, 3'd5, 3'd3, 2'd0, 1'b0, 32'h12340000, 32'h12340000}, // R2 zero fill
        '{8'd2, 1'b0, 3'd5, 3'd3, 2'd1, 1'b0, 32'h12340000, 32'h1234FF00}, // R2 one fill
        '{8'd1, 1'b0, 3'd3, 3'd1, 2'd0, 1'b0, 32'hA5FFFFFF, 32'hA5000000}, // R1 mask
        '{8'd4, 1'b0, 3'd3, 3'd5, 2'd0, 1'b1, 32'h12348000, 32'h12340000}, // R4 chop
        '{8'd5, 1'b0, 3'd3, 3'd5, 2'd0, 1'b0, 32'h12348000, 32'h12350000}, // R5 round up
        '{8'd5, 1'b0, 3'd3, 3'd5, 2'd0, 1'b0, 32'h12347F00, 32'h12340000}, // R5 round down
        '{8'd5, 1'b0, 3'd3, 3'd5, 2'd0, 1'b0, 32'h7FFF8000, 32'h7FFF0000}, // R5 saturate
        '{8'd5, 1'b0, 3'd3, 3'd5, 2'd0, 1'b0, 32'hFFFF8000, 32'h00000000}, // R5 negative half
        '{8'd1, 1'b0, 3'd7, 3'd7, 2'd0, 1'b0, 32'h89ABCDEF, 32'h89ABCDEF}, // R1 equal
        '{8'd2, 1'b0, 3'd7, 3'd0, 2'd1, 1'b0, 32'h90000000, 32'h9FFFFFFF}, // R2 4 to 32
        '{8'd5, 1'b0, 3'd0, 3'd7, 2'd0, 1'b0, 32'h5C000000, 32'h60000000}, // R5 32 to 4
        '{8'd5, 1'b0, 3'd0, 3'd7, 2'd0, 1'b0, 32'h7FFFFFFF, 32'h70000000}, // R5 saturate 4
        '{8'd6, 1'b1, 3'd3, 3'd5, 2'd0, 1'b0, 32'h1234C000, 32'h12340000}, // R6 receive
        '{8'd6, 1'b0, 3'd3, 3'd5, 2'd0, 1'b0, 32'h1234C000, 32'h12350000}  // R6 transmit
    };

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] expv);
        nchk++;
        if (got !== expv) begin
            nerr++;
            $display("FAIL %s got %h expected %h", tag, got, expv);
        end
    endtask

    task automatic send(input logic [31:0] dat, input logic [2:0] ch);
        @(negedge clk);
        in_valid = 1'b1; in_data = dat; in_chan = ch;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic pop(input string tag, input logic [2:0] ch, input logic [31:0] dat);
        logic [34:0] e;
        if (mon_q.size() == 0) begin
            nchk++; nerr++;
            $display("FAIL %s got no output expected %h/%h", tag, ch, dat);
        end else begin
            e = mon_q.pop_front();
            chk(tag, {29'd0, e}, {29'd0, ch, dat});
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        mon_q.delete();
    endtask

    logic [15:0] lf;
    function automatic logic [15:0] lstep(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    initial begin
        #400000;
        nerr++; nchk++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R12 reset out_valid/in_ready", {62'd0, out_valid, in_ready}, 64'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 after release", {62'd0, out_valid, in_ready}, 64'd1);

        for (int i = 0; i < NV; i++) begin
            cfg_dir = TBL[i].dir; cfg_aud_width = TBL[i].aw; cfg_cli_width = TBL[i].cw;
            cfg_fill = TBL[i].fill; cfg_chop = TBL[i].chop;
            send(TBL[i].din, 3'd0);
            settle();
            pop($sformatf("R%0d vector %0d", TBL[i].req, i), 3'd0, TBL[i].expv);
        end

        // R3 pseudo-random fill from a fresh reset
        do_reset();
        cfg_dir = 1'b0; cfg_cli_width = 3'd3; cfg_aud_width = 3'd7; cfg_fill = 2'd2;
        lf = 16'hACE1;
        send(32'h12340000, 3'd0); settle();
        pop("R3 first random fill", 3'd0, 32'h12340000 | {16'd0, lf});
        lf = lstep(lf);
        send(32'hABCD0000, 3'd0); settle();
        pop("R3 second random fill", 3'd0, 32'hABCD0000 | {16'd0, lf});

        // Fold stereo to mono at 32 bits
        cfg_fill = 2'd0; cfg_cli_width = 3'd7; cfg_aud_width = 3'd7;
        cfg_cli_chans = 3'd1; cfg_aud_chans = 3'd0;
        cfg_fold = 2'd0;
        send(32'h10000000, 3'd0); settle();
        chk("R7 held channel 0 gives no output", {32'd0, mon_q.size()}, 64'd0);
        send(32'h20000000, 3'd1); settle();
        pop("R7 fold mode 0", 3'd0, 32'h10000000);
        cfg_fold = 2'd1;
        send(32'h10000000, 3'd0); send(32'h20000000, 3'd1); settle();
        pop("R7 fold mode 1", 3'd0, 32'h20000000);
        cfg_fold = 2'd2;
        send(32'h00000003, 3'd0); send(32'h00000004, 3'd1); settle();
        pop("R8 average rounds down", 3'd0, 32'h00000003);
        send(32'h80000000, 3'd0); send(32'h80000000, 3'd1); settle();
        pop("R8 average no overflow", 3'd0, 32'h80000000);
        cfg_fold = 2'd3;
        send(32'hFFFFFFFD, 3'd0); send(32'h00000000, 3'd1); settle();
        pop("R8 negative average mode 3", 3'd0, 32'hFFFFFFFE);

        // Expand mono to stereo
        cfg_cli_chans = 3'd0; cfg_aud_chans = 3'd1; cfg_dup = 1'b0;
        send(32'h11110000, 3'd0); settle();
        pop("R9 expand first", 3'd0, 32'h11110000);
        pop("R9 expand zero second", 3'd1, 32'h00000000);
        cfg_dup = 1'b1;
        send(32'h22220000, 3'd0); settle();
        pop("R9 copy first", 3'd0, 32'h22220000);
        pop("R9 copy second", 3'd1, 32'h22220000);

        // Channel range handling
        cfg_cli_chans = 3'd3; cfg_aud_chans = 3'd1;
        send(32'h33330000, 3'd3); settle();
        chk("R10 channel beyond destination dropped", {32'd0, mon_q.size()}, 64'd0);
        send(32'h44440000, 3'd1); settle();
        pop("R10 channel index kept", 3'd1, 32'h44440000);
        cfg_cli_chans = 3'd1; cfg_aud_chans = 3'd1;
        send(32'h55550000, 3'd2); settle();
        chk("R10 channel beyond source dropped", {32'd0, mon_q.size()}, 64'd0);

        // Back-pressure
        cfg_cli_chans = 3'd0; cfg_aud_chans = 3'd0;
        out_ready = 1'b0;
        send(32'h66660000, 3'd0); settle();
        chk("R11 held output", {29'd0, out_valid, in_ready, out_data}, {29'd0, 1'b1, 1'b0, 32'h66660000});
        out_ready = 1'b1;
        settle();
        pop("R11 released output", 3'd0, 32'h66660000);
        chk("R11 nothing extra", {32'd0, mon_q.size()}, 64'd0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule